// File: doc/BRIEF.md
# Stallable Instruction Fetch Unit

This block is the fetch stage of a five-stage 32-bit pipeline. It holds the program counter and the instruction store. Every cycle a small next-address selector picks one of three named decisions. NA_SEQ moves the PC to PC + 4. NA_JUMP loads an externally supplied branch target. NA_HOLD keeps the PC where it is, and is used when a later stage needs the fetch to wait. The selector does not compute branch targets and does not decide whether a branch is taken. Both arrive as inputs.

The instruction store is a word-addressed array of 2^IDX_W 32-bit words. The production setting is IDX_W = 14, giving 16K words. The default parameter is smaller so that the default elaboration stays small. The store is filled through a load port that is honoured only while reset is held. During operation the store is read-only. Its read is combinational from the PC. PC bits [1:0] and every bit above the word index are ignored, so fetch addresses wrap modulo 4·2^IDX_W bytes. The outputs are the fetched word and the value PC + 4.

The selector has three decisions and one reset override. Reset forces PC = 0. Otherwise stall gives NA_HOLD, a taken branch gives NA_JUMP, and anything else gives NA_SEQ.

Top module: `ifu_fetch_top`

## Requirements
- R1: With stall and branch-taken both low, the PC advances by 4 on the next rising edge (decision NA_SEQ).
- R2: With stall low and branch-taken high, the PC takes the 32-bit branch target on the next edge (decision NA_JUMP).
- R3: With stall high, the PC keeps its value across the edge (decision NA_HOLD).
- R4: When stall and branch-taken are both high, stall wins and the PC does not change.
- R5: Synchronous reset (active high) sets the PC to 0 and takes priority over stall. After reset, pc_plus4_o reads 4 and instr_o reads store word 0.
- R6: instr_o is store word PC[IDX_W+1:2]. It is combinational, so it changes in the same cycle as the PC.
- R7: PC bits [1:0] do not affect which word is fetched, although they are kept in the PC and in pc_plus4_o.
- R8: PC bits above IDX_W+1 do not affect which word is fetched, so a target of 4·2^IDX_W fetches word 0.
- R9: A load-port write (ld_we_i high, word ld_addr_i, data ld_data_i) changes the store only on an edge where reset is high. Writes at other times leave the store unchanged.
- R10: pc_plus4_o equals PC + 4 modulo 2^32, so a PC of 0xFFFFFFFC gives 0 and the next sequential PC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze the PC this cycle |
| br_taken_i | input | 1 | Load br_target_i instead of PC + 4 |
| br_target_i | input | 32 | Branch target byte address |
| ld_we_i | input | 1 | Store load strobe, honoured only during reset |
| ld_addr_i | input | IDX_W | Store word index for loading |
| ld_data_i | input | 32 | Store load data |
| instr_o | output | 32 | Instruction word at the current PC |
| pc_plus4_o | output | 32 | Current PC plus 4 |

## Verification
A wrong PC is visible one edge after the decision that produced it. It shows at once on pc_plus4_o and, through the combinational read, on instr_o in the same cycle. Index slicing errors are caught by targets that carry set low bits or bits above the store range: they fetch the wrong word while pc_plus4_o still looks correct. A store corrupted by a write outside reset stays hidden until that word is fetched, so the bench branches straight to the affected address.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        NA_SEQ  = 2'd0,
        NA_JUMP = 2'd1,
        NA_HOLD = 2'd2
    } na_sel_e;

endpackage

// File: rtl/ifu_next_addr.sv
module ifu_next_addr
    import ifu_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic            stall,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] pc_plus4
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    na_sel_e sel;

    assign pc_plus4 = pc + STEP;

    always_comb begin
        if (stall)         sel = NA_HOLD;
        else if (br_taken) sel = NA_JUMP;
        else               sel = NA_SEQ;
    end

    always_comb begin
        unique case (sel)
            NA_SEQ:  pc_next = pc_plus4;
            NA_JUMP: pc_next = br_target;
            NA_HOLD: pc_next = pc;
            default: pc_next = pc;
        endcase
    end

endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg
    import ifu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    input  logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] pc_q
);

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
        (!stall && !br_taken) |=> (pc_q == $past(pc_q) + XLEN'(4)));  // R1

    AST_PC_JUMP: assert property (@(posedge clk) disable iff (rst)
        (!stall && br_taken) |=> (pc_q == $past(br_target)));  // R2

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stall && br_taken) |=> $stable(pc_q));  // R4

    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc_q));  // R3

    AST_PC_RESET: assert property (@(posedge clk)
        rst |=> (pc_q == '0));  // R5

endmodule

// File: rtl/ifu_istore.sv
module ifu_istore
    import ifu_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [XLEN-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst && ld_we) mem[ld_addr] <= ld_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/ifu_fetch_top.sv
module ifu_fetch_top
    import ifu_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall_i,
    input  logic             br_taken_i,
    input  logic [31:0]      br_target_i,
    input  logic             ld_we_i,
    input  logic [IDX_W-1:0] ld_addr_i,
    input  logic [31:0]      ld_data_i,
    output logic [31:0]      instr_o,
    output logic [31:0]      pc_plus4_o
);

    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_W + IDX_LO - 1;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_plus4;

    ifu_next_addr u_next (
        .pc        (pc_q),
        .stall     (stall_i),
        .br_taken  (br_taken_i),
        .br_target (br_target_i),
        .pc_next   (pc_next),
        .pc_plus4  (pc_plus4)
    );

    ifu_pc_reg u_pc (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall_i),
        .br_taken  (br_taken_i),
        .br_target (br_target_i),
        .pc_next   (pc_next),
        .pc_q      (pc_q)
    );

    ifu_istore #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .ld_we   (ld_we_i),
        .ld_addr (ld_addr_i),
        .ld_data (ld_data_i),
        .rd_idx  (pc_q[IDX_HI:IDX_LO]),
        .rd_data (instr_o)
    );

    assign pc_plus4_o = pc_plus4;

endmodule

// File: tb/ifu_fetch_top_tb_top.sv
module ifu_fetch_top_tb_top;

    localparam int IDX_W = 10;
    localparam int DEPTH = 1 << IDX_W;
    localparam int NVEC  = 12;

    // {stall, br_taken, target, expected PC after the edge}
    localparam logic [65:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0004},  // R1
        {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0008},  // R1
        {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0008},  // R3
        {1'b0, 1'b1, 32'h0000_0100, 32'h0000_0100},  // R2
        {1'b1, 1'b1, 32'h0000_0200, 32'h0000_0100},  // R4
        {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0104},  // R1
        {1'b0, 1'b1, 32'h0000_1002, 32'h0000_1002},  // R7 R8
        {1'b0, 1'b0, 32'h0000_0000, 32'h0000_1006},  // R7
        {1'b0, 1'b1, 32'hFFFF_FFFC, 32'hFFFF_FFFC},  // R10
        {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},  // R10
        {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000},  // R3
        {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0004}   // R1
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             stall_i = 1'b0;
    logic             br_taken_i = 1'b0;
    logic [31:0]      br_target_i = '0;
    logic             ld_we_i = 1'b0;
    logic [IDX_W-1:0] ld_addr_i = '0;
    logic [31:0]      ld_data_i = '0;
    logic [31:0]      instr_o;
    logic [31:0]      pc_plus4_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ifu_fetch_top #(.IDX_W(IDX_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .stall_i     (stall_i),
        .br_taken_i  (br_taken_i),
        .br_target_i (br_target_i),
        .ld_we_i     (ld_we_i),
        .ld_addr_i   (ld_addr_i),
        .ld_data_i   (ld_data_i),
        .instr_o     (instr_o),
        .pc_plus4_o  (pc_plus4_o)
    );

    function automatic logic [31:0] word_of(input int idx);
        return 32'hC0DE_0000 + 32'(idx);
    endfunction

    function automatic int idx_of(input logic [31:0] pc);
        return int'((pc >> 2) & 32'(DEPTH - 1));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_pc(input string req, input logic [31:0] pc, input logic [31:0] wexp);
        check(req, pc_plus4_o, pc + 32'd4);
        check(req, instr_o, wexp);
    endtask

    initial begin
        // preload the store during reset
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            ld_we_i   = 1'b1;
            ld_addr_i = IDX_W'(i);
            ld_data_i = word_of(i);
            @(negedge clk);
        end
        ld_we_i = 1'b0;
        // R5 reset state
        check_pc("R5 reset", 32'h0, word_of(0));
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            stall_i     = VEC[v][65];
            br_taken_i  = VEC[v][64];
            br_target_i = VEC[v][63:32];
            @(negedge clk);
            // R1 R2 R3 R4 R6 R7 R8 R10
            check_pc($sformatf("R6 vector %0d", v), VEC[v][31:0], word_of(idx_of(VEC[v][31:0])));
        end
        stall_i = 1'b0;
        br_taken_i = 1'b0;

        // R10 explicit wrap of pc_plus4
        br_taken_i = 1'b1; br_target_i = 32'hFFFF_FFFC;
        @(negedge clk);
        br_taken_i = 1'b0;
        check("R10 plus4 wrap", pc_plus4_o, 32'h0);

        // R9 write outside reset is ignored
        ld_we_i = 1'b1; ld_addr_i = IDX_W'(5); ld_data_i = 32'hBAD0_BAD0;
        @(negedge clk);
        ld_we_i = 1'b0;
        br_taken_i = 1'b1; br_target_i = 32'h14;
        @(negedge clk);
        br_taken_i = 1'b0;
        check("R9 write ignored", instr_o, word_of(5));

        // R5 reset beats stall; R9 write during reset lands
        stall_i = 1'b1; rst = 1'b1;
        ld_we_i = 1'b1; ld_addr_i = IDX_W'(6); ld_data_i = 32'hDEAD_BEEF;
        @(negedge clk);
        ld_we_i = 1'b0;
        check("R5 reset over stall", pc_plus4_o, 32'h4);
        rst = 1'b0; stall_i = 1'b0;
        br_taken_i = 1'b1; br_target_i = 32'h18;
        @(negedge clk);
        br_taken_i = 1'b0;
        check("R9 write in reset", instr_o, 32'hDEAD_BEEF);

        // R8 high bits ignored, R7 low bits ignored
        br_taken_i = 1'b1; br_target_i = 32'h8000_1017;
        @(negedge clk);
        br_taken_i = 1'b0;
        check("R8 R7 index", instr_o, word_of(5));
        check("R7 plus4 keeps low bits", pc_plus4_o, 32'h8000_101B);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule